// File: doc/BRIEF.md
# Ping-Pong Isochronous Receive Buffer

This block buffers the receive side of an isochronous OUT endpoint. It has two packet stores, side A and side B, which take turns frame by frame. Each start-of-frame pulse hands the store just filled over to the CPU read port and points the write port at the other store. The write port takes an OUT-token strobe, a stream of valid bytes and an end-of-packet strobe that carries an error flag. The error flag comes from the packet checker upstream.

Every side keeps its own internal success flag, failure flag and stored-byte count. None of these is visible while its frame runs. At the next frame boundary the values of the closing side are copied into the visible status. The visible status therefore describes the previous frame, and the data of frame N can be read throughout frame N+1.

The CPU reads bytes one at a time from the store that is not being written. It steps through them with a read strobe that advances an internal pointer. The pointer returns to byte 0 at every swap.

Top module: `iso_pingpong_rx`

## Requirements
- R1: After reset the write port targets side A (`wr_side_o` = 0, where 0 means A and 1 means B), and `stat_ok_o`, `stat_fail_o` and `rd_count_o` are all 0.
- R2: Every cycle with `sof_i` high inverts `wr_side_o`, and `wr_side_o` is otherwise constant. Reads always address the other side. After each swap the first byte returned is byte 0 of that side.
- R3: A packet opened by `tok_i` and closed by `eop_i` with `eop_err_i` low, and without overflow, sets the success flag of the side being written. If `eop_err_i` is high it sets the failure flag instead. The two visible flags are never both 1.
- R4: `stat_ok_o`, `stat_fail_o` and `rd_count_o` change only in the cycle after `sof_i`, and they then hold the values of the side just closed.
- R5: Bytes stored in frame N are returned in arrival order during frame N+1, one per `rd_en_i` cycle. Bytes written during frame N+1 do not disturb those reads and become readable only after the following `sof_i`.
- R6: At most `max_pkt_i` bytes are stored per packet, and a value above 128 counts as 128. Any byte past the limit is dropped, the count stops at the limit, and the packet ends with the failure flag. With a limit of 0, a non-empty packet stores nothing and fails.
- R7: A frame with no `tok_i` publishes both flags 0 and count 0. Bytes that arrive when no packet is open are ignored.
- R8: When `eop_i` arrives in the same cycle as `sof_i`, the completion counts for the side being closed and is published by that same `sof_i`.
- R9: A second `tok_i` within a frame restarts the packet. The count and both flags of the active side are cleared, and writing resumes at byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse |
| tok_i | input | 1 | OUT token received, opens a packet |
| wr_valid_i | input | 1 | Data byte valid |
| wr_data_i | input | 8 | Received data byte |
| eop_i | input | 1 | End of packet |
| eop_err_i | input | 1 | Packet data error, qualified by `eop_i` |
| max_pkt_i | input | 8 | Maximum packet size in bytes, 0 to 128 |
| rd_en_i | input | 1 | Advance the read pointer |
| rd_data_o | output | 8 | Byte at the read pointer of the read side |
| rd_count_o | output | 8 | Published byte count |
| stat_ok_o | output | 1 | Published success flag |
| stat_fail_o | output | 1 | Published failure flag |
| wr_side_o | output | 1 | Side currently written (0 = A, 1 = B) |

## Verification
The end of a packet and the frame boundary can fall in the same cycle. The result then depends on whether the completion lands in the closing side before its flags are copied out. The bench provokes this by holding back the end-of-packet strobe of one frame and raising it together with the next `sof_i`. The scoreboard then expects success and the full count in the status published by that very swap. While the CPU drains the previous frame's bytes, the driver fills the other side at the same time. This confirms that reads and writes never touch the same store.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/iso_rx_wrctl.sv
module iso_rx_wrctl
    import iso_rx_pkg::*;
#(
    parameter int MAX_BYTES = 128,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              tok_i,
    input  logic              wr_valid_i,
    input  logic              eop_i,
    input  logic              eop_err_i,
    input  logic [CNT_W-1:0]  max_pkt_i,
    output side_e             side_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              pub_ok_o,
    output logic              pub_fail_o,
    output logic [CNT_W-1:0]  pub_cnt_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    typedef struct packed {
        side_e                  side;
        logic                   active;
        logic                   ovf;
        logic [1:0]             ok;
        logic [1:0]             fail;
        logic [1:0][CNT_W-1:0]  cnt;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             cur;
    logic             take;
    logic             room;
    logic             ovf_now;

    always_comb begin
        st_d       = st_q;
        we_o       = 1'b0;
        waddr_o    = '0;
        cur        = st_q.side;
        limit      = (max_pkt_i > MAX_CNT) ? MAX_CNT : max_pkt_i;
        take       = st_q.active && wr_valid_i && !tok_i;
        room       = st_q.cnt[cur] < limit;
        ovf_now    = st_q.ovf || (take && !room);

        if (tok_i) begin
            st_d.active    = 1'b1;
            st_d.ovf       = 1'b0;
            st_d.ok[cur]   = 1'b0;
            st_d.fail[cur] = 1'b0;
            st_d.cnt[cur]  = '0;
        end else begin
            if (take) begin
                if (room) begin
                    we_o          = 1'b1;
                    waddr_o       = st_q.cnt[cur][ADDR_W-1:0];
                    st_d.cnt[cur] = st_q.cnt[cur] + CNT_W'(1);
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
            if (st_q.active && eop_i) begin
                st_d.active = 1'b0;
                st_d.ovf    = 1'b0;
                if (eop_err_i || ovf_now) begin
                    st_d.fail[cur] = 1'b1;
                end else begin
                    st_d.ok[cur] = 1'b1;
                end
            end
        end

        // values of the closing side, including this cycle's completion
        pub_ok_o   = st_d.ok[cur];
        pub_fail_o = st_d.fail[cur];
        pub_cnt_o  = st_d.cnt[cur];

        if (sof_i) begin
            st_d.side       = side_e'(~cur);
            st_d.active     = 1'b0;
            st_d.ovf        = 1'b0;
            st_d.ok[~cur]   = 1'b0;
            st_d.fail[~cur] = 1'b0;
            st_d.cnt[~cur]  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{side: SIDE_A, active: 1'b0, ovf: 1'b0,
                      ok: '0, fail: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign side_o = st_q.side;
endmodule

// File: rtl/iso_rx_pub.sv
module iso_rx_pub #(
    parameter int MAX_BYTES = 128,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              rd_en_i,
    input  logic              pub_ok_i,
    input  logic              pub_fail_i,
    input  logic [CNT_W-1:0]  pub_cnt_i,
    output logic              stat_ok_o,
    output logic              stat_fail_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] rptr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MAX_BYTES - 1);

    typedef struct packed {
        logic              ok;
        logic              fail;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] rptr;
    } pub_state_t;

    pub_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof_i) begin
            st_d.ok   = pub_ok_i;
            st_d.fail = pub_fail_i;
            st_d.cnt  = pub_cnt_i;
            st_d.rptr = '0;
        end else if (rd_en_i) begin
            st_d.rptr = (st_q.rptr == LAST_ADDR) ? '0 : st_q.rptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_ok_o   = st_q.ok;
    assign stat_fail_o = st_q.fail;
    assign count_o     = st_q.cnt;
    assign rptr_o      = st_q.rptr;
endmodule

// File: rtl/iso_rx_buf.sv
module iso_rx_buf
    import iso_rx_pkg::*;
#(
    parameter int MAX_BYTES = 128,
    parameter int DATA_W    = 8,
    localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int SIDES  = 2
) (
    input  logic              clk,
    input  side_e             wr_side_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] bank_rd [SIDES];
    side_e             rd_side;

    assign rd_side = side_e'(~wr_side_i);

    for (genvar b = 0; b < SIDES; b++) begin : g_bank
        logic [DATA_W-1:0] mem [MAX_BYTES];

        always_ff @(posedge clk) begin
            if (we_i && (wr_side_i == side_e'(b))) begin
                mem[waddr_i] <= wdata_i;
            end
        end

        assign bank_rd[b] = mem[raddr_i];
    end

    assign rdata_o = bank_rd[rd_side];
endmodule

// File: rtl/iso_pingpong_rx.sv
module iso_pingpong_rx
    import iso_rx_pkg::*;
#(
    parameter int MAX_BYTES = 128,
    parameter int DATA_W    = 8,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              tok_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              eop_i,
    input  logic              eop_err_i,
    input  logic [CNT_W-1:0]  max_pkt_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  rd_count_o,
    output logic              stat_ok_o,
    output logic              stat_fail_o,
    output logic              wr_side_o
);
    side_e             side;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] rptr;
    logic              pub_ok;
    logic              pub_fail;
    logic [CNT_W-1:0]  pub_cnt;

    iso_rx_wrctl #(.MAX_BYTES(MAX_BYTES)) u_wrctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .tok_i      (tok_i),
        .wr_valid_i (wr_valid_i),
        .eop_i      (eop_i),
        .eop_err_i  (eop_err_i),
        .max_pkt_i  (max_pkt_i),
        .side_o     (side),
        .we_o       (we),
        .waddr_o    (waddr),
        .pub_ok_o   (pub_ok),
        .pub_fail_o (pub_fail),
        .pub_cnt_o  (pub_cnt)
    );

    iso_rx_pub #(.MAX_BYTES(MAX_BYTES)) u_pub (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .rd_en_i     (rd_en_i),
        .pub_ok_i    (pub_ok),
        .pub_fail_i  (pub_fail),
        .pub_cnt_i   (pub_cnt),
        .stat_ok_o   (stat_ok_o),
        .stat_fail_o (stat_fail_o),
        .count_o     (rd_count_o),
        .rptr_o      (rptr)
    );

    iso_rx_buf #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .wr_side_i (side),
        .we_i      (we),
        .waddr_i   (waddr),
        .wdata_i   (wr_data_i),
        .raddr_i   (rptr),
        .rdata_o   (rd_data_o)
    );

    assign wr_side_o = side;
endmodule

// File: rtl/iso_rx_chk.sv
module iso_rx_chk #(
    parameter int MAX_BYTES = 128,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_i,
    input logic             wr_side_o,
    input logic             stat_ok_o,
    input logic             stat_fail_o,
    input logic [CNT_W-1:0] rd_count_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    AST_SIDE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (wr_side_o != $past(wr_side_o)));                          // R2

    AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable(wr_side_o));                                      // R2

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_ok_o && stat_fail_o));                                        // R3

    AST_STATUS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable({stat_ok_o, stat_fail_o, rd_count_o}));           // R4

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count_o <= MAX_CNT);                                              // R6
endmodule

bind iso_pingpong_rx iso_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_i       (sof_i),
    .wr_side_o   (wr_side_o),
    .stat_ok_o   (stat_ok_o),
    .stat_fail_o (stat_fail_o),
    .rd_count_o  (rd_count_o)
);

// File: tb/sim_iso_pingpong_rx.sv
module sim_iso_pingpong_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof_i = 1'b0;
    logic       tok_i = 1'b0;
    logic       wr_valid_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       eop_i = 1'b0;
    logic       eop_err_i = 1'b0;
    logic [7:0] max_pkt_i = 8'd128;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [7:0] rd_count_o;
    logic       stat_ok_o;
    logic       stat_fail_o;
    logic       wr_side_o;

    always #2.5 clk = ~clk;

    iso_pingpong_rx u0 (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .tok_i(tok_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .eop_i(eop_i),
        .eop_err_i(eop_err_i), .max_pkt_i(max_pkt_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .rd_count_o(rd_count_o), .stat_ok_o(stat_ok_o),
        .stat_fail_o(stat_fail_o), .wr_side_o(wr_side_o)
    );

    typedef struct {
        bit    ok;
        bit    fail;
        int    cnt;
        int    base;
        string req;
    } exp_t;

    exp_t q[$];
    event pub_ev;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;
    bit   busy = 0;
    bit   pend_eop = 0;
    bit   pend_err = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_sof();
        int prev_side;
        @(negedge clk);
        prev_side = int'(wr_side_o);
        sof_i     = 1'b1;
        eop_i     = pend_eop;
        eop_err_i = pend_err;
        @(negedge clk);
        sof_i     = 1'b0;
        eop_i     = 1'b0;
        eop_err_i = 1'b0;
        pend_eop  = 0;
        pend_err  = 0;
        chk("R2 side swap", int'(wr_side_o), prev_side ^ 1);
        ->pub_ev;
    endtask

    task automatic send_bytes(int n, int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid_i = 1'b1;
            wr_data_i  = 8'(base + i);
        end
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic token();
        @(negedge clk); tok_i = 1'b1;
        @(negedge clk); tok_i = 1'b0;
    endtask

    // driver: one frame, expected published status pushed to the scoreboard
    task automatic frame(bit tok, int n, bit err, int maxp, int base,
                         bit eop_on_sof, bit stray, bit restart, string req);
        exp_t e;
        int   lim;
        int   s_ok, s_fail, s_cnt;
        max_pkt_i = 8'(maxp);
        do_sof();
        #1;
        s_ok = int'(stat_ok_o); s_fail = int'(stat_fail_o); s_cnt = int'(rd_count_o);
        if (stray) send_bytes(3, 8'hE0);
        if (tok) begin
            token();
            if (restart) begin
                send_bytes(n, 8'h90);
                token();
            end
            send_bytes(n, base);
            if (eop_on_sof) begin
                pend_eop = 1; pend_err = err;
            end else begin
                @(negedge clk); eop_i = 1'b1; eop_err_i = err;
                @(negedge clk); eop_i = 1'b0; eop_err_i = 1'b0;
            end
        end
        lim    = (maxp > 128) ? 128 : maxp;
        e.fail = tok && (err || n > lim);
        e.ok   = tok && !e.fail;
        e.cnt  = tok ? ((n < lim) ? n : lim) : 0;
        e.base = base;
        e.req  = req;
        q.push_back(e);
        repeat (200) @(negedge clk);
        chk("R4 status held in frame", int'({stat_ok_o, stat_fail_o}), (s_ok << 1) | s_fail);
        chk("R4 count held in frame", int'(rd_count_o), s_cnt);
    endtask

    // monitor: compare published status and drain the read side
    initial begin
        exp_t e;
        forever begin
            @(pub_ev);
            busy = 1;
            if (q.size() == 0) begin
                chk("R4 scoreboard underflow", 1, 0);
            end else begin
                e = q.pop_front();
                chk({e.req, " ok flag"},   int'(stat_ok_o),   int'(e.ok));
                chk({e.req, " fail flag"}, int'(stat_fail_o), int'(e.fail));
                chk({e.req, " count"},     int'(rd_count_o),  e.cnt);
                for (int i = 0; i < e.cnt; i++) begin
                    chk({e.req, " R5 data"}, int'(rd_data_o), (e.base + i) & 255);
                    rd_en_i = 1'b1;
                    @(negedge clk);
                end
                rd_en_i = 1'b0;
            end
            busy = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        exp_t e0;
        repeat (3) @(negedge clk);
        chk("R1 reset side", int'(wr_side_o), 0);
        chk("R1 reset ok", int'(stat_ok_o), 0);
        chk("R1 reset fail", int'(stat_fail_o), 0);
        chk("R1 reset count", int'(rd_count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 side after release", int'(wr_side_o), 0);
        e0.ok = 0; e0.fail = 0; e0.cnt = 0; e0.base = 0; e0.req = "R1 first publish";
        q.push_back(e0);
        //     tok n    err max  base   late stray rst
        frame(1, 10,  0, 128, 8'h10, 0, 0, 0, "R3 clean packet");
        frame(1, 7,   1, 128, 8'h30, 0, 0, 0, "R3 error packet");
        frame(0, 0,   0, 128, 8'h00, 0, 1, 0, "R7 empty frame");
        frame(1, 20,  0, 12,  8'h40, 0, 0, 0, "R6 overflow");
        frame(1, 130, 0, 200, 8'h00, 0, 0, 0, "R6 clamp");
        frame(1, 128, 0, 128, 8'h80, 0, 0, 0, "R6 full size");
        frame(1, 1,   0, 0,   8'h55, 0, 0, 0, "R6 zero max");
        frame(1, 4,   0, 128, 8'hA0, 0, 0, 1, "R9 restart");
        frame(1, 6,   0, 128, 8'hC0, 1, 0, 0, "R8 eop on sof");
        frame(1, 0,   0, 128, 8'h00, 0, 0, 0, "R3 zero length");
        do_sof();
        #1;
        while (busy || q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule